// File: doc/BRIEF.md
# Flash Completion Status Poller

This controller sits on the host side of a parallel flash device and waits for a self-timed program or erase to finish. After the command sequence has been issued elsewhere, the host pulses `start_i` and supplies the byte address to watch, the data byte it expects there, and a polling method. For an erase the address does not matter and the expected byte is FFh. For a program, the target address and the byte just written are given.

The poller then issues single-byte reads, one at a time, over a request/acknowledge port. It looks at the status bits of each returned byte and decides whether the operation is complete. In data-poll mode it compares bit 7 with the expected data. In toggle mode it looks for bit 6 to stop changing between reads. If bit 5 reports that the device timed out, the poller does not fail at once. It makes a confirming check first, because the device may have finished just as the flag rose. A read budget ends the run as a failure if no verdict arrives. The result is reported with a one-cycle done pulse and a pass flag that holds its value.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o` and `pass_o` are all 0.
- R2: A `start_i` seen while idle captures `addr_i`, `expect_i` and `mode_i` (0 selects data polling, 1 selects toggle polling). From the next cycle on, `rd_req_o` is 1 and `rd_addr_o` equals the captured address. A read completes in each cycle where both `rd_req_o` and `rd_ack_i` are 1. `rd_req_o` stays 1 until a verdict is reached.
- R3: In data-poll mode, a read whose bit 7 equals bit 7 of the expected byte gives a pass.
- R4: In data-poll mode, a read whose bit 7 differs from the expected bit and whose bit 5 is 0 leads to another read.
- R5: In data-poll mode, a read whose bit 7 differs and whose bit 5 is 1 leads to exactly one more read. That read passes if its bit 7 matches and fails otherwise.
- R6: In toggle mode, the first read only serves as a reference. A later read whose bit 6 equals bit 6 of the read just before it gives a pass.
- R7: In toggle mode, a read whose bit 6 differs from the previous read's and whose bit 5 is 1 leads to two more reads. The run fails if bit 6 differs between those two and passes if it is the same.
- R8: In toggle mode, a read whose bit 6 differs and whose bit 5 is 0 leads to another read. That read is compared against this one.
- R9: If `MAX_READS` reads complete with no verdict, the run ends as a failure, and no further read is issued.
- R10: `done_o` is 1 for exactly one cycle, the cycle after the deciding read. `pass_o` takes the verdict in that same cycle and holds it until the next accepted start, which clears it to 0.
- R11: A `start_i` that arrives while busy is ignored: the address, mode, expected data and progress of the run in flight are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a poll run (ignored while busy) |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle polling on bit 6 |
| addr_i | input | ADDR_W | Byte address to poll |
| expect_i | input | 8 | Expected data byte (FFh for erase) |
| rd_req_o | output | 1 | Read request, held until a verdict is reached |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid in that cycle |
| rd_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict, held until the next accepted start |
| busy_o | output | 1 | A poll run is in progress |

## Verification
On every cycle, the assertions check four things:
- the done pulse is one cycle long and always follows a completed read;
- a run never exceeds its read budget;
- the pass flag stays still while the block is idle;
- a start that arrives mid-run leaves the read address untouched.

Whether a verdict is right can only be shown by the bench's scenarios. These cover the bit 5 confirmation paths in both modes, the spin-then-pass sequences, and the budget expiring in each mode. The bench compares each verdict and its read count with a reference model, under random acknowledge delays.

// File: rtl/poller_pkg.sv
`timescale 1ns/1ps
package poller_pkg;
    localparam int DATA_W      = 8;
    localparam int POLL_BIT    = 7;
    localparam int TOGGLE_BIT  = 6;
    localparam int TIMEOUT_BIT = 5;

    typedef enum logic [2:0] {
        PH_DPOLL  = 3'd0,
        PH_DCONF  = 3'd1,
        PH_TFIRST = 3'd2,
        PH_TPOLL  = 3'd3,
        PH_TCONF1 = 3'd4,
        PH_TCONF2 = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        V_CONT = 2'd0,
        V_PASS = 2'd1,
        V_FAIL = 2'd2
    } verdict_e;
endpackage

// File: rtl/poll_judge.sv
`timescale 1ns/1ps
module poll_judge
    import poller_pkg::*;
(
    input  phase_e   phase_i,
    input  logic     exp7_i,
    input  logic     prev6_i,
    input  logic     d7_i,
    input  logic     d6_i,
    input  logic     d5_i,
    output verdict_e verdict_o,
    output phase_e   phase_o,
    output logic     prev6_o
);
    always_comb begin
        verdict_o = V_CONT;
        phase_o   = phase_i;
        prev6_o   = prev6_i;
        case (phase_i)
            PH_DPOLL: begin
                if (d7_i == exp7_i) verdict_o = V_PASS;
                else if (d5_i)      phase_o   = PH_DCONF;
            end
            PH_DCONF: verdict_o = (d7_i == exp7_i) ? V_PASS : V_FAIL;
            PH_TFIRST: begin
                prev6_o = d6_i;
                phase_o = PH_TPOLL;
            end
            PH_TPOLL: begin
                if (d6_i == prev6_i) begin
                    verdict_o = V_PASS;
                end else begin
                    prev6_o = d6_i;
                    if (d5_i) phase_o = PH_TCONF1;
                end
            end
            PH_TCONF1: begin
                prev6_o = d6_i;
                phase_o = PH_TCONF2;
            end
            PH_TCONF2: verdict_o = (d6_i == prev6_i) ? V_PASS : V_FAIL;
            default:   verdict_o = V_FAIL;
        endcase
    end
endmodule

// File: rtl/read_budget.sv
`timescale 1ns/1ps
module read_budget #(
    parameter int MAX_READS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_READS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(MAX_READS - 1));
endmodule

// File: rtl/flash_status_poller.sv
`timescale 1ns/1ps
module flash_status_poller
    import poller_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int MAX_READS = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              busy_o
);
    typedef struct packed {
        logic              busy;
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              exp7;
        logic              prev6;
        logic              done;
        logic              pass;
    } state_t;

    state_t   st_d, st_q;
    verdict_e verdict;
    phase_e   phase_nx;
    logic     prev6_nx;
    logic     rd_done;
    logic     accept;
    logic     budget_last;
    logic     unused_bits;

    assign rd_done     = st_q.busy && rd_ack_i;
    assign accept      = !st_q.busy && start_i;
    assign unused_bits = ^{rd_data_i[4:0], expect_i[6:0]};

    poll_judge u_judge (
        .phase_i   (st_q.phase),
        .exp7_i    (st_q.exp7),
        .prev6_i   (st_q.prev6),
        .d7_i      (rd_data_i[POLL_BIT]),
        .d6_i      (rd_data_i[TOGGLE_BIT]),
        .d5_i      (rd_data_i[TIMEOUT_BIT]),
        .verdict_o (verdict),
        .phase_o   (phase_nx),
        .prev6_o   (prev6_nx)
    );

    read_budget #(.MAX_READS(MAX_READS)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .tick_i  (rd_done),
        .last_o  (budget_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.phase = mode_i ? PH_TFIRST : PH_DPOLL;
            st_d.addr  = addr_i;
            st_d.exp7  = expect_i[POLL_BIT];
            st_d.pass  = 1'b0;
        end else if (rd_done) begin
            if (verdict == V_PASS) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.pass = 1'b1;
            end else if (verdict == V_FAIL || budget_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.pass = 1'b0;
            end else begin
                st_d.phase = phase_nx;
                st_d.prev6 = prev6_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_DPOLL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_o  = st_q.busy;
    assign rd_addr_o = st_q.addr;
    assign done_o    = st_q.done;
    assign pass_o    = st_q.pass;
    assign busy_o    = st_q.busy;
endmodule

// File: rtl/poller_checks.sv
`timescale 1ns/1ps
module poller_checks #(
    parameter int ADDR_W    = 17,
    parameter int MAX_READS = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic              rd_ack_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              busy_o
);
    int rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rd_cnt <= 0;
        else if (!busy_o && start_i) rd_cnt <= 0;
        else if (rd_req_o && rd_ack_i) rd_cnt <= rd_cnt + 1;
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(rd_req_o && rd_ack_i)));

    a_r10_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(pass_o));

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(rd_addr_o));

    a_r9_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_cnt < MAX_READS));
endmodule

bind flash_status_poller poller_checks #(.ADDR_W(ADDR_W), .MAX_READS(MAX_READS)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .rd_addr_o (rd_addr_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .busy_o    (busy_o)
);

// File: tb/flash_status_poller_test.sv
`timescale 1ns/1ps
module flash_status_poller_test;
    localparam int AW = 17;
    localparam int WD = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          ack = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    expv = '0;
    logic [7:0]    rdata = '0;
    logic          rd_req_o, done_o, pass_o, busy_o;
    logic [AW-1:0] rd_addr_o;

    logic [7:0] seq [16];
    int checks = 0;
    int errors = 0;

    flash_status_poller #(.ADDR_W(AW), .MAX_READS(WD)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .addr_i(addr), .expect_i(expv), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(ack), .rd_data_i(rdata),
        .done_o(done_o), .pass_o(pass_o), .busy_o(busy_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: reads taken and verdict for the sequence in seq.
    function automatic void model(input bit m, input bit e7,
                                  output int reads, output bit ok);
        bit prev;
        reads = WD;
        ok    = 1'b0;
        if (!m) begin
            for (int i = 0; i < WD; i++) begin
                if (seq[i][7] == e7) begin reads = i + 1; ok = 1'b1; return; end
                if (seq[i][5]) begin
                    if (i + 1 >= WD) return;
                    reads = i + 2;
                    ok = (seq[i+1][7] == e7);
                    return;
                end
            end
        end else begin
            prev = seq[0][6];
            for (int i = 1; i < WD; i++) begin
                if (seq[i][6] == prev) begin reads = i + 1; ok = 1'b1; return; end
                if (seq[i][5]) begin
                    if (i + 2 > WD - 1) return;
                    reads = i + 3;
                    ok = (seq[i+1][6] == seq[i+2][6]);
                    return;
                end
                prev = seq[i][6];
            end
        end
    endfunction

    task automatic fill(input bit m, input bit e7);
        for (int i = 0; i < 16; i++)
            seq[i] = m ? {1'b0, i[0], 6'h00} : {~e7, 7'h00};
    endtask

    task automatic run(input bit m, input logic [AW-1:0] a, input logic [7:0] e,
                       input bit poke, input string tag);
        int  er;
        int  idx;
        bit  eo;
        bit  pa;
        bit  seen;
        model(m, e[7], er, eo);
        @(negedge clk);
        start = 1'b1; mode = m; addr = a; expv = e; ack = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(rd_req_o == 1'b1, "R2", "request after start", int'(rd_req_o), 1);
        check(rd_addr_o == a, "R2", "read address", int'(rd_addr_o), int'(a));
        check(pass_o == 1'b0, "R10", "pass cleared on start", int'(pass_o), 0);
        idx = 0;
        ack = ($urandom % 4) != 0;
        rdata = seq[0];
        pa = ack;
        seen = 1'b0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (pa) idx++;
            if (done_o) begin seen = 1'b1; break; end
            if (!rd_req_o || rd_addr_o != a) begin
                check(1'b0, "R11", "request/address held during run",
                      int'(rd_addr_o), int'(a));
                break;
            end
            ack = ($urandom % 4) != 0;
            rdata = (idx < 16) ? seq[idx] : 8'h00;
            pa = ack;
            if (poke && ($urandom % 3 == 0)) begin
                start = 1'b1; mode = ~m; addr = ~a; expv = ~e;
            end
        end
        ack = 1'b0;
        check(seen, tag, "done pulse seen", int'(seen), 1);
        check(pass_o == eo, tag, "verdict", int'(pass_o), int'(eo));
        check(idx == er, tag, "reads taken", idx, er);
        @(negedge clk);
        check(done_o == 1'b0, "R10", "done is one cycle", int'(done_o), 0);
        check(pass_o == eo, "R10", "pass holds", int'(pass_o), int'(eo));
        check(rd_req_o == 1'b0, "R9", "no read after verdict", int'(rd_req_o), 0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL bench timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy_o == 0 && rd_req_o == 0, "R1", "idle in reset",
              int'({busy_o, rd_req_o}), 0);
        check(done_o == 0 && pass_o == 0, "R1", "outputs low in reset",
              int'({done_o, pass_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0, "R1", "idle after reset",
              int'({busy_o, done_o}), 0);

        fill(0, 1); seq[0] = 8'h80;                       run(0, 17'h00123, 8'hFF, 0, "R3");
        fill(0, 1); seq[2] = 8'h80;                       run(0, 17'h1F000, 8'hFF, 0, "R4");
        fill(0, 0); seq[0] = 8'h80; seq[1] = 8'h00;       run(0, 17'h00042, 8'h35, 0, "R3");
        fill(0, 1); seq[0] = 8'h20; seq[1] = 8'h20;       run(0, 17'h00001, 8'hFF, 0, "R5");
        fill(0, 1); seq[0] = 8'h20; seq[1] = 8'hA0;       run(0, 17'h00002, 8'hFF, 0, "R5");
        fill(1, 1); seq[0] = 8'h40; seq[1] = 8'h00; seq[2] = 8'h00;
                                                          run(1, 17'h00010, 8'hFF, 0, "R6");
        fill(1, 1); seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h00; seq[3] = 8'h00;
                                                          run(1, 17'h00011, 8'hFF, 0, "R8");
        fill(1, 1); seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h00; seq[3] = 8'h40;
                                                          run(1, 17'h00012, 8'hFF, 0, "R7");
        fill(1, 1); seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h40; seq[3] = 8'h40;
                                                          run(1, 17'h00013, 8'hFF, 0, "R7");
        fill(0, 1);                                       run(0, 17'h0AAAA, 8'hFF, 0, "R9");
        fill(1, 1);                                       run(1, 17'h05555, 8'hFF, 0, "R9");
        fill(0, 1); seq[9] = 8'h80;                       run(0, 17'h01234, 8'hFF, 1, "R11");
        fill(1, 1); seq[7] = 8'h40;                       run(1, 17'h04321, 8'hFF, 1, "R11");

        for (int n = 0; n < 40; n++) begin
            bit         m;
            logic [7:0] e;
            m = 1'($urandom % 2);
            e = 8'($urandom);
            for (int i = 0; i < 16; i++) begin
                logic [7:0] d;
                d = 8'($urandom);
                d[5] = ($urandom % 6) == 0;
                if (!m) d[7] = (($urandom % 5) == 0) ? e[7] : ~e[7];
                seq[i] = d;
            end
            run(m, AW'($urandom), e, 1'($urandom % 2), m ? "R6/R7/R8" : "R3/R4/R5");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule